// File: doc/BRIEF.md
# Mode-banked processor register file

This block stores the architectural register state of a 32-bit processor core. Sixteen architectural registers, indexed 0 to 15, are presented to the datapath. Which physical storage sits behind each index depends on a 5-bit processor mode input. The fast-interrupt mode swaps in private copies of indices 8 to 14. Each of the other four exception modes swaps in a private pair for indices 13 and 14. Indices 0 to 7 and index 15, the program counter, are always shared. Index 15 is an ordinary writable register.

The datapath uses two combinational read ports and one write port that commits on the rising clock edge. A separate status port reaches the single current status word, or the saved status word that belongs to the current mode, depending on a selector input. Instruction decode, exception entry sequencing and program-counter increment are handled elsewhere. The mode input is driven by the surrounding core, usually from the mode field of the current status word.

Top module: `regfile_banked`

## Requirements
- R1: After reset every general register reads 0, the current status word reads 0x000000D3 (bits 4:0 = 10011, supervisor; bits 7 and 6 set), and every saved status word reads 0.
- R2: Reads are combinational. A write with `wr_en` high commits at the rising clock edge into the physical register chosen by the mode applied during that cycle. A mode change after the edge does not move the written value.
- R3: Indices 0 to 7 map to the same physical registers in every mode.
- R4: Index 15 is one physical register in every mode.
- R5: In fast-interrupt mode (10001), indices 8 to 14 use seven private registers. Writes to them there are invisible in user mode, and user-mode writes to them are invisible in fast-interrupt mode.
- R6: Supervisor (10011), abort (10111), interrupt (10010) and undefined (11011) modes each have a private pair for indices 13 and 14. In these modes, indices 8 to 12 read the user-mode registers.
- R7: Any mode code other than the six listed codes (user is 10000) behaves exactly as user mode for reads and writes.
- R8: If a read and a write target the same physical register in the same cycle, the read returns the value held before the write. There is no bypass, on either port.
- R9: With `psr_sel` = 0 the status port reaches the one current status word, which is shared by all modes. With `psr_sel` = 1 it reaches the saved status word of the current exception mode, and there are five separate saved words.
- R10: In user mode, a read with `psr_sel` = 1 returns the current status word, and a write with `psr_sel` = 1 changes no status word.
- R11: The two read ports select and return registers independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 5 | Processor mode code selecting the register bank |
| rd_a_idx | input | 4 | Architectural index, read port A |
| rd_a_data | output | 32 | Read data, port A (combinational) |
| rd_b_idx | input | 4 | Architectural index, read port B |
| rd_b_data | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable, general registers |
| wr_idx | input | 4 | Architectural index of the write |
| wr_data | input | 32 | Write data |
| psr_sel | input | 1 | 0 = current status word, 1 = saved status word of the mode |
| psr_wr_en | input | 1 | Status write enable |
| psr_wr_data | input | 32 | Status write data |
| psr_rd_data | output | 32 | Status read data (combinational) |

## Verification
The assertions assume that the mode, indices and enables are stable and known around each rising edge. They also assume that the mode compared across two cycles is the mode the surrounding core actually applied, so a mode change between a write and the following read is treated as moving to a different bank. The directed stimulus changes every input only on the falling edge and samples outputs a few nanoseconds later. Each write pattern is chosen so that every value identifies the mode and index it was written under, which means a value read from the wrong bank can never match the expected value by accident.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
    localparam int DATA_W    = 32;
    localparam int ARCH_N    = 16;
    localparam int AIDX_W    = $clog2(ARCH_N);
    localparam int MODE_W    = 5;
    localparam int FIQ_LO    = 8;
    localparam int FIQ_HI    = 14;
    localparam int FIQ_CNT   = FIQ_HI - FIQ_LO + 1;
    localparam int PAIR_LO   = 13;
    localparam int PAIR_CNT  = 2;
    localparam int EXC_PAIRS = 4;
    localparam int PHYS_N    = ARCH_N + FIQ_CNT + EXC_PAIRS * PAIR_CNT;
    localparam int PIDX_W    = $clog2(PHYS_N);
    localparam int SPSR_N    = 1 + EXC_PAIRS;
    localparam int FIQ_BASE  = ARCH_N;
    localparam int SVC_BASE  = FIQ_BASE + FIQ_CNT;
    localparam int ABT_BASE  = SVC_BASE + PAIR_CNT;
    localparam int IRQ_BASE  = ABT_BASE + PAIR_CNT;
    localparam int UND_BASE  = IRQ_BASE + PAIR_CNT;

    localparam logic [MODE_W-1:0] MC_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MC_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MC_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MC_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MC_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MC_UND = 5'b11011;

    localparam logic [DATA_W-1:0] PSR_RESET = 32'h0000_00D3;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_SVC = 3'd2,
        BK_ABT = 3'd3,
        BK_IRQ = 3'd4,
        BK_UND = 3'd5
    } bank_e;
endpackage

// File: rtl/bankrf_mode_decode.sv
module bankrf_mode_decode
    import bankrf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output bank_e             bank_o
);
    always_comb begin
        unique case (mode_i)
            MC_FIQ:  bank_o = BK_FIQ;
            MC_SVC:  bank_o = BK_SVC;
            MC_ABT:  bank_o = BK_ABT;
            MC_IRQ:  bank_o = BK_IRQ;
            MC_UND:  bank_o = BK_UND;
            default: bank_o = BK_USR;
        endcase
    end
endmodule

// File: rtl/bankrf_index_map.sv
module bankrf_index_map
    import bankrf_pkg::*;
(
    input  bank_e             bank_i,
    input  logic [AIDX_W-1:0] arch_i,
    output logic [PIDX_W-1:0] phys_o
);
    int  arch_int;
    int  pair_base;
    logic in_fiq_range;
    logic in_pair_range;

    always_comb begin
        arch_int      = int'(arch_i);
        in_fiq_range  = (arch_int >= FIQ_LO) && (arch_int <= FIQ_HI);
        in_pair_range = (arch_int >= PAIR_LO) && (arch_int < PAIR_LO + PAIR_CNT);
        pair_base     = 0;
        phys_o        = PIDX_W'(arch_int);
        unique case (bank_i)
            BK_FIQ: begin
                if (in_fiq_range) phys_o = PIDX_W'(FIQ_BASE + arch_int - FIQ_LO);
            end
            BK_SVC, BK_ABT, BK_IRQ, BK_UND: begin
                unique case (bank_i)
                    BK_SVC:  pair_base = SVC_BASE;
                    BK_ABT:  pair_base = ABT_BASE;
                    BK_IRQ:  pair_base = IRQ_BASE;
                    default: pair_base = UND_BASE;
                endcase
                if (in_pair_range) phys_o = PIDX_W'(pair_base + arch_int - PAIR_LO);
            end
            default: phys_o = PIDX_W'(arch_int);
        endcase
    end
endmodule

// File: rtl/bankrf_status.sv
module bankrf_status
    import bankrf_pkg::*;
#(
    parameter int                DW       = DATA_W,
    parameter logic [DW-1:0]     RST_WORD = PSR_RESET
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bank_e         bank_i,
    input  logic          sel_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] cur_o
);
    logic [DW-1:0] cur_q;
    logic [DW-1:0] saved_q [SPSR_N];
    logic          is_user;
    logic [DW-1:0] saved_rd;

    assign is_user = (bank_i == BK_USR);

    always_ff @(posedge clk) begin
        if (!rst_n)                cur_q <= RST_WORD;
        else if (we_i && !sel_i)   cur_q <= wdata_i;
    end

    for (genvar s = 0; s < SPSR_N; s++) begin : g_saved
        always_ff @(posedge clk) begin
            if (!rst_n)
                saved_q[s] <= '0;
            else if (we_i && sel_i && !is_user && (int'(bank_i) == s + 1))
                saved_q[s] <= wdata_i;
        end
    end

    always_comb begin
        saved_rd = cur_q;
        for (int s = 0; s < SPSR_N; s++)
            if (int'(bank_i) == s + 1) saved_rd = saved_q[s];
    end

    assign rdata_o = (sel_i && !is_user) ? saved_rd : cur_q;
    assign cur_o   = cur_q;
endmodule

// File: rtl/regfile_banked.sv
module regfile_banked
    import bankrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic [AIDX_W-1:0] rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [AIDX_W-1:0] rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [AIDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              psr_sel,
    input  logic              psr_wr_en,
    input  logic [DATA_W-1:0] psr_wr_data,
    output logic [DATA_W-1:0] psr_rd_data
);
    localparam int NPORT = 3;

    bank_e             bank;
    logic [AIDX_W-1:0] arch_idx [NPORT];
    logic [PIDX_W-1:0] phys_idx [NPORT];
    logic [DATA_W-1:0] gpr_q    [PHYS_N];
    logic [DATA_W-1:0] cpsr_w;

    bankrf_mode_decode u_dec (
        .mode_i (mode),
        .bank_o (bank)
    );

    assign arch_idx[0] = rd_a_idx;
    assign arch_idx[1] = rd_b_idx;
    assign arch_idx[2] = wr_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        bankrf_index_map u_map (
            .bank_i (bank),
            .arch_i (arch_idx[p]),
            .phys_o (phys_idx[p])
        );
    end

    for (genvar g = 0; g < PHYS_N; g++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (!rst_n)
                gpr_q[g] <= '0;
            else if (wr_en && (int'(phys_idx[2]) == g))
                gpr_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_a_data = '0;
        rd_b_data = '0;
        for (int g = 0; g < PHYS_N; g++) begin
            if (int'(phys_idx[0]) == g) rd_a_data = gpr_q[g];
            if (int'(phys_idx[1]) == g) rd_b_data = gpr_q[g];
        end
    end

    bankrf_status #(
        .DW       (DATA_W),
        .RST_WORD (PSR_RESET)
    ) u_psr (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_i  (bank),
        .sel_i   (psr_sel),
        .we_i    (psr_wr_en),
        .wdata_i (psr_wr_data),
        .rdata_o (psr_rd_data),
        .cur_o   (cpsr_w)
    );
endmodule

// File: rtl/regfile_banked_chk.sv
module regfile_banked_chk
    import bankrf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode,
    input logic [AIDX_W-1:0] rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [AIDX_W-1:0] rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [AIDX_W-1:0] wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              psr_sel,
    input logic              psr_wr_en,
    input logic [DATA_W-1:0] psr_wr_data,
    input logic [DATA_W-1:0] psr_rd_data,
    input logic [DATA_W-1:0] cpsr
);
    logic user_like;
    assign user_like = !(mode == MC_FIQ || mode == MC_SVC || mode == MC_ABT ||
                         mode == MC_IRQ || mode == MC_UND);

    a_r1_reset_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cpsr == PSR_RESET));

    a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && (mode == $past(mode)) && (rd_a_idx == $past(wr_idx)))
        |-> (rd_a_data == $past(wr_data)));

    a_r3_low_shared: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && ($past(wr_idx) < 4'd8) && (rd_b_idx == $past(wr_idx)))
        |-> (rd_b_data == $past(wr_data)));

    a_r4_pc_shared: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && ($past(wr_idx) == 4'd15) && (rd_a_idx == 4'd15))
        |-> (rd_a_data == $past(wr_data)));

    a_r9_cur_status_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(psr_wr_en) && !$past(psr_sel) && !psr_sel)
        |-> (psr_rd_data == $past(psr_wr_data)));

    a_r10_user_saved_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        (psr_wr_en && psr_sel && user_like) |=> $stable(cpsr));
endmodule

bind regfile_banked regfile_banked_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .rd_a_idx    (rd_a_idx),
    .rd_a_data   (rd_a_data),
    .rd_b_idx    (rd_b_idx),
    .rd_b_data   (rd_b_data),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .psr_sel     (psr_sel),
    .psr_wr_en   (psr_wr_en),
    .psr_wr_data (psr_wr_data),
    .psr_rd_data (psr_rd_data),
    .cpsr        (cpsr_w)
);

// File: tb/sim_regfile_banked.sv
module sim_regfile_banked;
    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode = M_USR;
    logic [3:0]  rd_a_idx = '0;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_idx = '0;
    logic [31:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        psr_sel = 1'b0;
    logic        psr_wr_en = 1'b0;
    logic [31:0] psr_wr_data = '0;
    logic [31:0] psr_rd_data;

    int checks = 0;
    int errors = 0;

    logic [4:0] exc4 [4] = '{M_SVC, M_ABT, M_IRQ, M_UND};
    logic [4:0] all6 [6] = '{M_USR, M_FIQ, M_SVC, M_ABT, M_IRQ, M_UND};

    always #10 clk = ~clk;

    regfile_banked u0 (
        .clk (clk), .rst_n (rst_n), .mode (mode),
        .rd_a_idx (rd_a_idx), .rd_a_data (rd_a_data),
        .rd_b_idx (rd_b_idx), .rd_b_data (rd_b_data),
        .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
        .psr_sel (psr_sel), .psr_wr_en (psr_wr_en),
        .psr_wr_data (psr_wr_data), .psr_rd_data (psr_rd_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] m, logic [3:0] i, logic [31:0] d);
        @(negedge clk);
        mode = m; wr_en = 1'b1; wr_idx = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [4:0] m, logic [3:0] i, logic [31:0] exp);
        @(negedge clk);
        mode = m; rd_a_idx = i; rd_b_idx = i;
        #2;
        check(req, rd_a_data, exp);
    endtask

    task automatic psr_wr(logic [4:0] m, logic s, logic [31:0] d);
        @(negedge clk);
        mode = m; psr_sel = s; psr_wr_en = 1'b1; psr_wr_data = d;
        @(negedge clk);
        psr_wr_en = 1'b0;
    endtask

    task automatic psr_chk(string req, logic [4:0] m, logic s, logic [31:0] exp);
        @(negedge clk);
        mode = m; psr_sel = s;
        #2;
        check(req, psr_rd_data, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 R0 after reset", M_USR, 4'd0, 32'h0);
        rd_chk("R1 fiq R9 after reset", M_FIQ, 4'd9, 32'h0);
        rd_chk("R1 svc R13 after reset", M_SVC, 4'd13, 32'h0);
        psr_chk("R1 current status reset", M_USR, 1'b0, 32'h0000_00D3);
        psr_chk("R1 saved status fiq reset", M_FIQ, 1'b1, 32'h0);
        psr_chk("R1 saved status und reset", M_UND, 1'b1, 32'h0);
    endtask

    task automatic t_shared();
        for (int i = 0; i < 8; i++) wr(all6[i % 6], 4'(i), 32'h0000_0100 + i);
        for (int m = 0; m < 6; m++)
            for (int i = 0; i < 8; i++)
                rd_chk("R3 low index shared", all6[m], 4'(i), 32'h0000_0100 + i);
        wr(M_IRQ, 4'd15, 32'h0000_8000);
        for (int m = 0; m < 6; m++)
            rd_chk("R4 program counter shared", all6[m], 4'd15, 32'h0000_8000);
    endtask

    task automatic t_fiq();
        for (int i = 8; i < 15; i++) wr(M_USR, 4'(i), 32'h0000_A000 + i);
        for (int i = 8; i < 15; i++) wr(M_FIQ, 4'(i), 32'h0000_F000 + i);
        for (int i = 8; i < 15; i++) begin
            rd_chk("R5 user copy untouched", M_USR, 4'(i), 32'h0000_A000 + i);
            rd_chk("R5 fiq private copy", M_FIQ, 4'(i), 32'h0000_F000 + i);
        end
    endtask

    task automatic t_pairs();
        for (int k = 0; k < 4; k++) begin
            wr(exc4[k], 4'd13, 32'h0000_B00D + (k << 8));
            wr(exc4[k], 4'd14, 32'h0000_B00E + (k << 8));
        end
        for (int k = 0; k < 4; k++) begin
            rd_chk("R6 private R13", exc4[k], 4'd13, 32'h0000_B00D + (k << 8));
            rd_chk("R6 private R14", exc4[k], 4'd14, 32'h0000_B00E + (k << 8));
            for (int i = 8; i < 13; i++)
                rd_chk("R6 R8-R12 from user set", exc4[k], 4'(i), 32'h0000_A000 + i);
        end
        rd_chk("R6 user R13 untouched", M_USR, 4'd13, 32'h0000_A00D);
        rd_chk("R6 fiq R14 untouched", M_FIQ, 4'd14, 32'h0000_F00E);
    endtask

    task automatic t_unknown_mode();
        rd_chk("R7 odd code reads user R13", 5'b11111, 4'd13, 32'h0000_A00D);
        rd_chk("R7 odd code reads user R9", 5'b00001, 4'd9, 32'h0000_A009);
        wr(5'b00000, 4'd14, 32'h0000_C0DE);
        rd_chk("R7 odd code write lands in user", M_USR, 4'd14, 32'h0000_C0DE);
        rd_chk("R7 odd code write spares svc", M_SVC, 4'd14, 32'h0000_B00E);
    endtask

    task automatic t_read_during_write();
        @(negedge clk);
        mode = M_USR; wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'h5555_0002;
        rd_a_idx = 4'd2; rd_b_idx = 4'd2;
        #2;
        check("R8 port A old value", rd_a_data, 32'h0000_0102);
        check("R8 port B old value", rd_b_data, 32'h0000_0102);
        @(negedge clk);
        wr_en = 1'b0;
        #2;
        check("R2 value after edge", rd_a_data, 32'h5555_0002);
        @(negedge clk);
        mode = M_FIQ; wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'h7777_0009;
        @(negedge clk);
        wr_en = 1'b0; mode = M_USR; rd_a_idx = 4'd9;
        #2;
        check("R2 mode change after edge, user R9", rd_a_data, 32'h0000_A009);
        rd_chk("R2 write went to fiq R9", M_FIQ, 4'd9, 32'h7777_0009);
    endtask

    task automatic t_two_ports();
        @(negedge clk);
        mode = M_SVC; rd_a_idx = 4'd1; rd_b_idx = 4'd13;
        #2;
        check("R11 port A independent", rd_a_data, 32'h0000_0101);
        check("R11 port B independent", rd_b_data, 32'h0000_B00D);
        rd_a_idx = 4'd15; rd_b_idx = 4'd5;
        #2;
        check("R11 port A swap", rd_a_data, 32'h0000_8000);
        check("R11 port B swap", rd_b_data, 32'h0000_0105);
    endtask

    task automatic t_status();
        psr_wr(M_SVC, 1'b0, 32'h6000_001F);
        for (int m = 0; m < 6; m++)
            psr_chk("R9 current status shared", all6[m], 1'b0, 32'h6000_001F);
        psr_wr(M_FIQ, 1'b1, 32'h0000_1001);
        for (int k = 0; k < 4; k++) psr_wr(exc4[k], 1'b1, 32'h0000_2000 + k);
        psr_chk("R9 fiq saved word", M_FIQ, 1'b1, 32'h0000_1001);
        for (int k = 0; k < 4; k++)
            psr_chk("R9 saved word per mode", exc4[k], 1'b1, 32'h0000_2000 + k);
        psr_chk("R9 current untouched by saved writes", M_USR, 1'b0, 32'h6000_001F);
    endtask

    task automatic t_user_saved();
        psr_chk("R10 user saved read gives current", M_USR, 1'b1, 32'h6000_001F);
        psr_wr(M_USR, 1'b1, 32'hDEAD_BEEF);
        psr_chk("R10 current unchanged", M_USR, 1'b0, 32'h6000_001F);
        psr_chk("R10 fiq saved unchanged", M_FIQ, 1'b1, 32'h0000_1001);
        psr_chk("R10 und saved unchanged", M_UND, 1'b1, 32'h0000_2003);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_shared();
        t_fiq();
        t_pairs();
        t_unknown_mode();
        t_read_during_write();
        t_two_ports();
        t_status();
        t_user_saved();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule